// File: doc/BRIEF.md
# H4 Packet Receive Framer

The framer sits behind a UART receiver and turns its byte stream into whole host-controller packets in the H4 style. The first byte of each packet is a type code. The framer collects two bytes and then decides how long the header is. When the header is complete, it reads the payload length from the header. It then stores bytes until the packet is complete. Every accepted byte is written into a local packet buffer at its offset within the packet. Downstream logic reads the buffer through a registered read port.

When the last byte of a packet is stored, the framer raises a one-cycle completion strobe. On the same edge it updates the type and total-length outputs. It then re-arms for the next packet. A packet whose announced length does not fit in the buffer is dropped, and its remaining bytes are counted off so that framing stays aligned. An unknown type code is fatal: the framer stops until reset.

Top module: `h4_rx_framer`

## Requirements
- R1: After reset, `pkt_done`, `ovf_drop` and `frame_err` are 0, `pkt_type` is 0 and `pkt_len` is 0.
- R2: The header field sizes, not counting the type byte, depend on the type code:
  - Type 1 (command) has a 3-byte header, and its payload length is byte 3.
  - Type 4 (event) has a 2-byte header, and its payload length is byte 2.
  - Type 3 (SCO) has a 3-byte header, and its payload length is byte 3.
  - Type 2 (ACL) has a 4-byte header, and its payload length is bytes 3 (low) and 4 (high), little-endian.
  - The packet total is 1 + header + payload. Byte offsets count from the type byte at 0.
- R3: For a command whose opcode in bytes 1 (low) and 2 (high) equals 0xFC00, the payload length is byte 3 rounded up to the next even value. Every other opcode uses byte 3 unchanged.
- R4: A type 6 (negotiation) packet has a total of byte 1 + 2 bytes and no payload. A type 7 (keep-alive) packet is always 4 bytes.
- R5: `pkt_done` is high for exactly one cycle, following the clock edge that stores the last byte of a packet. `pkt_type` and `pkt_len` are updated on that edge and hold until the next completion.
- R6: Byte k of the last completed packet is at buffer address k. `rd_data` shows the byte at `rd_addr` one cycle after the address is applied. The contents stay valid until bytes of the next packet arrive.
- R7: A byte presented while `enable` is low or `in_valid` is low is ignored. It is neither stored nor counted.
- R8: If the total length computed at the end of the header exceeds DEPTH, `ovf_drop` pulses for one cycle and no completion is signalled. The framer then discards the announced number of payload bytes, and the next byte starts a new packet.
- R9: A packet whose total equals DEPTH exactly is accepted and completed normally.
- R10: Any type code other than 1, 2, 3, 4, 6 or 7 raises `frame_err` when the second byte is stored. The flag then holds until reset, and no completion or overflow is signalled while it is set.
- R11: The header decision is taken after exactly two bytes. A negotiation packet whose byte 1 is 0 therefore completes on its second byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Accept bytes when high |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_data | input | 8 | Received byte |
| rd_addr | input | AW | Packet buffer read address |
| rd_data | output | 8 | Buffer byte, one cycle after `rd_addr` |
| pkt_done | output | 1 | One-cycle packet completion strobe |
| pkt_type | output | 8 | Type code of the last completed packet |
| pkt_len | output | LW | Total byte count of the last completed packet |
| ovf_drop | output | 1 | One-cycle pulse: packet too long, dropped |
| frame_err | output | 1 | Sticky: unknown type code seen |

## Verification
The assertions check, on every cycle, the properties that hold whatever the stream contains:
- the completion strobe never lasts two cycles;
- nothing completes or overflows without an accepted byte in the cycle before;
- a completed length stays between 2 and DEPTH, and its type is a legal code;
- the error flag is sticky and silences all other events;
- the length and type outputs stay stable between completions.

Only the bench's scenarios can show that each type yields the right total length. The same holds for the even rounding of the special opcode, the byte-for-byte buffer contents, and the exact discard count after an overflow. These all depend on the header values the bench supplies.

// File: rtl/h4_rx_framer.sv
`timescale 1ns/1ps
module h4_rx_framer #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          pkt_done,
  output logic [7:0]    pkt_type,
  output logic [LW-1:0] pkt_len,
  output logic          ovf_drop,
  output logic          frame_err
);
  localparam int CW = 17;
  localparam logic [CW-1:0] DEPTH_W = CW'(DEPTH);

  typedef enum logic [2:0] {ST_TYPE, ST_HDR, ST_BODY, ST_SKIP, ST_HALT} st_t;

  st_t           st;
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt, hdr_need, need, hdr_total, total;
  logic [15:0]   skip_left, payload;
  logic [8:0]    plen9;
  logic [7:0]    b0, b1, b2, b3;
  logic          bad_type;

  wire           take = enable && in_valid;
  wire [CW-1:0]  held = cnt + CW'(1);
  wire           storing = take && (st == ST_TYPE || st == ST_HDR || st == ST_BODY);

  always_comb begin
    bad_type  = 1'b0;
    hdr_total = CW'(4);
    case (b0)
      8'd1, 8'd3, 8'd7: hdr_total = CW'(4);
      8'd2:             hdr_total = CW'(5);
      8'd4:             hdr_total = CW'(3);
      8'd6:             hdr_total = CW'(in_data) + CW'(2);
      default:          bad_type = 1'b1;
    endcase
  end

  always_comb begin
    plen9 = {1'b0, in_data};
    if ({b2, b1} == 16'hFC00) plen9 = plen9 + {8'd0, in_data[0]};
    case (b0)
      8'd1:       payload = {7'd0, plen9};
      8'd2:       payload = {in_data, b3};
      8'd3, 8'd4: payload = {8'd0, in_data};
      default:    payload = 16'd0;
    endcase
  end

  assign total = hdr_need + CW'(payload);

  always_ff @(posedge clk) begin
    if (storing) mem[cnt[AW-1:0]] <= in_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_TYPE;
      cnt       <= '0;
      hdr_need  <= '0;
      need      <= '0;
      skip_left <= '0;
      b0 <= '0; b1 <= '0; b2 <= '0; b3 <= '0;
      pkt_done  <= 1'b0;
      pkt_type  <= '0;
      pkt_len   <= '0;
      ovf_drop  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      pkt_done <= 1'b0;
      ovf_drop <= 1'b0;
      if (storing) begin
        case (cnt)
          CW'(0): b0 <= in_data;
          CW'(1): b1 <= in_data;
          CW'(2): b2 <= in_data;
          CW'(3): b3 <= in_data;
          default: ;
        endcase
      end
      if (take) begin
        case (st)
          ST_TYPE: begin
            if (cnt == '0) begin
              cnt <= CW'(1);
            end else if (bad_type) begin
              st        <= ST_HALT;
              frame_err <= 1'b1;
            end else if (hdr_total == CW'(2)) begin
              pkt_done <= 1'b1;
              pkt_type <= b0;
              pkt_len  <= LW'(2);
              cnt      <= '0;
            end else begin
              hdr_need <= hdr_total;
              cnt      <= CW'(2);
              st       <= ST_HDR;
            end
          end
          ST_HDR: begin
            if (held != hdr_need) begin
              cnt <= held;
            end else if (payload == 16'd0) begin
              pkt_done <= 1'b1;
              pkt_type <= b0;
              pkt_len  <= held[LW-1:0];
              cnt      <= '0;
              st       <= ST_TYPE;
            end else if (total > DEPTH_W) begin
              ovf_drop  <= 1'b1;
              skip_left <= payload;
              cnt       <= '0;
              st        <= ST_SKIP;
            end else begin
              need <= total;
              cnt  <= held;
              st   <= ST_BODY;
            end
          end
          ST_BODY: begin
            if (held == need) begin
              pkt_done <= 1'b1;
              pkt_type <= b0;
              pkt_len  <= held[LW-1:0];
              cnt      <= '0;
              st       <= ST_TYPE;
            end else begin
              cnt <= held;
            end
          end
          ST_SKIP: begin
            skip_left <= skip_left - 16'd1;
            if (skip_left == 16'd1) st <= ST_TYPE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/h4_rx_framer_chk.sv
`timescale 1ns/1ps
module h4_rx_framer_chk #(
  parameter int DEPTH = 1024,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          in_valid,
  input logic          pkt_done,
  input logic [7:0]    pkt_type,
  input logic [LW-1:0] pkt_len,
  input logic          ovf_drop,
  input logic          frame_err
);
  localparam logic [LW-1:0] MAXLEN = LW'(DEPTH);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);

  assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_done |-> $stable(pkt_len) && $stable(pkt_type));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && in_valid) |=> !pkt_done && !ovf_drop);

  assert_len_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (pkt_len >= LW'(2)) && (pkt_len <= MAXLEN));

  assert_type_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (pkt_type inside {8'd1, 8'd2, 8'd3, 8'd4, 8'd6, 8'd7}));

  assert_ovf_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_drop |-> !pkt_done);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  assert_err_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !pkt_done && !ovf_drop);
endmodule

bind h4_rx_framer h4_rx_framer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
  .pkt_done(pkt_done), .pkt_type(pkt_type), .pkt_len(pkt_len),
  .ovf_drop(ovf_drop), .frame_err(frame_err)
);

// File: tb/sim_h4_rx_framer.sv
`timescale 1ns/1ps
module sim_h4_rx_framer;
  localparam int DEPTH = 1024;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic pkt_done, ovf_drop, frame_err;
  logic [7:0] pkt_type;
  logic [LW-1:0] pkt_len;

  always #2.5 clk = ~clk;

  h4_rx_framer #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
    .in_data(in_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pkt_done(pkt_done), .pkt_type(pkt_type), .pkt_len(pkt_len),
    .ovf_drop(ovf_drop), .frame_err(frame_err)
  );

  int nchk = 0, nfail = 0;
  logic [7:0] q[$], last_pkt[$], pk[$];
  int skip = 0;
  bit dead = 0;
  bit e_done, e_ovf;
  int e_type = 0, e_len = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int hdr_of(input logic [7:0] t, input logic [7:0] s);
    case (t)
      8'd1, 8'd3, 8'd7: return 4;
      8'd2: return 5;
      8'd4: return 3;
      8'd6: return int'(s) + 2;
      default: return -1;
    endcase
  endfunction

  task automatic model_byte(input logic [7:0] b);
    int n, h, p, tot;
    if (skip > 0) begin skip--; return; end
    q.push_back(b);
    n = q.size();
    if (n < 2) return;
    h = hdr_of(q[0], q[1]);
    if (h < 0) begin dead = 1; q.delete(); return; end
    if (n < h) return;
    p = 0;
    case (q[0])
      8'd1: begin p = q[3]; if ({q[2], q[1]} == 16'hFC00) p = p + (p % 2); end
      8'd2: p = {q[4], q[3]};
      8'd3: p = q[3];
      8'd4: p = q[2];
      default: p = 0;
    endcase
    tot = h + p;
    if (n == h && tot > DEPTH) begin
      e_ovf = 1; skip = p; q.delete(); return;
    end
    if (n == tot) begin
      e_done = 1; e_type = q[0]; e_len = tot; last_pkt = q; q.delete();
    end
  endtask

  task automatic step(input bit v, input bit en, input logic [7:0] b);
    in_valid = v; enable = en; in_data = b;
    @(posedge clk);
    e_done = 0; e_ovf = 0;
    if (v && en && !dead) model_byte(b);
    @(negedge clk);
    check(pkt_done == e_done, "R5 done", pkt_done, e_done);
    check(ovf_drop == e_ovf, "R8 ovf_drop", ovf_drop, e_ovf);
    check(frame_err == dead, "R10 frame_err", frame_err, dead);
    check(pkt_type == e_type[7:0], "R2 pkt_type", pkt_type, e_type);
    check(int'(pkt_len) == e_len, "R2 pkt_len", pkt_len, e_len);
  endtask

  task automatic send_pk();
    foreach (pk[i]) step(1'b1, 1'b1, pk[i]);
  endtask

  task automatic readback(input string req);
    foreach (last_pkt[k]) begin
      rd_addr = AW'(k);
      step(1'b0, 1'b1, 8'h00);
      check(rd_data == last_pkt[k], req, rd_data, last_pkt[k]);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 0; enable = 0;
    repeat (3) @(posedge clk);
    q.delete(); skip = 0; dead = 0; e_type = 0; e_len = 0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check(pkt_done == 0, "R1 done", pkt_done, 0);
    check(ovf_drop == 0, "R1 ovf", ovf_drop, 0);
    check(frame_err == 0, "R1 err", frame_err, 0);
    check(pkt_type == 0, "R1 type", pkt_type, 0);
    check(pkt_len == 0, "R1 len", pkt_len, 0);

    // R2 command, zero parameters
    pk = {8'h01, 8'h03, 8'h0c, 8'h00}; send_pk();
    check(e_len == 4, "R2 cmd len model", e_len, 4);
    // R2 command with params, R6 readback
    pk = {8'h01, 8'h01, 8'h10, 8'h03, 8'haa, 8'hbb, 8'hcc}; send_pk();
    readback("R6 cmd buffer");
    // R3 vendor opcode odd and even lengths
    pk = {8'h01, 8'h00, 8'hfc, 8'h03, 8'h11, 8'h22, 8'h33, 8'h44}; send_pk();
    check(int'(pkt_len) == 8, "R3 rounded len", pkt_len, 8);
    pk = {8'h01, 8'h00, 8'hfc, 8'h02, 8'h55, 8'h66}; send_pk();
    check(int'(pkt_len) == 6, "R3 even len", pkt_len, 6);
    // R2 event
    pk = {8'h04, 8'h0e, 8'h02, 8'h01, 8'h02}; send_pk();
    // R2 ACL 16-bit length with gaps between bytes (R7)
    pk = {8'h02, 8'h11, 8'h00, 8'h05, 8'h01};
    for (int i = 0; i < 261; i++) pk.push_back(8'(i * 7));
    foreach (pk[i]) begin
      step(1'b1, 1'b1, pk[i]);
      if (i % 50 == 3) step(1'b0, 1'b1, 8'hee);
    end
    check(int'(pkt_len) == 266, "R2 acl len", pkt_len, 266);
    readback("R6 acl buffer");
    // R2 SCO
    pk = {8'h03, 8'h22, 8'h00, 8'h02, 8'h9a, 8'hbc}; send_pk();
    // R4 negotiation and keep-alive
    pk = {8'h06, 8'h0a};
    for (int i = 0; i < 10; i++) pk.push_back(8'(i + 1));
    send_pk();
    check(int'(pkt_len) == 12, "R4 neg len", pkt_len, 12);
    pk = {8'h07, 8'h00, 8'h55, 8'h00}; send_pk();
    check(pkt_type == 8'h07, "R4 alive type", pkt_type, 7);
    // R11 two-byte negotiation
    pk = {8'h06, 8'h00}; send_pk();
    check(int'(pkt_len) == 2, "R11 min len", pkt_len, 2);
    // R7 disabled bytes ignored mid-packet
    step(1'b1, 1'b1, 8'h01); step(1'b1, 1'b1, 8'h05);
    step(1'b1, 1'b0, 8'hee); step(1'b1, 1'b0, 8'hef);
    step(1'b1, 1'b1, 8'h20); step(1'b1, 1'b1, 8'h00);
    check(int'(pkt_len) == 4, "R7 ignored len", pkt_len, 4);
    readback("R7 ignored buffer");
    // R8 overflow and realignment
    pk = {8'h02, 8'h33, 8'h00, 8'h4c, 8'h04};
    for (int i = 0; i < 1100; i++) pk.push_back(8'h07);
    send_pk();
    pk = {8'h07, 8'h00, 8'h55, 8'h00}; send_pk();
    check(int'(pkt_len) == 4, "R8 realigned", pkt_len, 4);
    // R9 exactly DEPTH
    pk = {8'h02, 8'h44, 8'h00, 8'hfb, 8'h03};
    for (int i = 0; i < 1019; i++) pk.push_back(8'(i ^ 8'h5a));
    send_pk();
    check(int'(pkt_len) == DEPTH, "R9 full len", pkt_len, DEPTH);
    readback("R9 full buffer");
    // R10 unknown type
    pk = {8'h05, 8'h00}; send_pk();
    check(frame_err == 1, "R10 err set", frame_err, 1);
    pk = {8'h07, 8'h00, 8'h55, 8'h00}; send_pk();
    do_reset();
    check(frame_err == 0, "R1 err after reset", frame_err, 0);
    pk = {8'h04, 8'h13, 8'h00}; send_pk();
    check(int'(pkt_len) == 3, "R2 evt empty", pkt_len, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule